// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block ranks the interrupt sources of a 16550-style serial port and reports the winner to the host. Four raw conditions arrive from the rest of the port: receive data ready (or receive trigger reached), transmit holding register empty, the four receive error flags, and the four modem-line change flags. The block keeps a pending flag for each source. It masks the flags with a 4-bit enable register that the host writes. It drives an identification byte and an active-high interrupt request.

Each source leaves the pending state on its own event. A line error stays pending until the line status register is read. A modem change stays pending until the modem status register is read. Receive data pending follows the data condition directly. Transmit-empty pending is cleared by a write to the holding register. It is also cleared by a read of the identification byte, but only while it is the reported source. One identification read is therefore enough for the handler to act on.

A change on any input is registered on a clock edge. It shows on `iir` and `irq` right after that edge.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `iir` reads 0x01, `irq` is 0, the enable register is 0, and no source is pending. A transmit-empty level already high at reset does not count as a new event.
- R2: A pulse on `ier_wr` stores `ier_wdata[3:0]` in the enable register. `ier_rdata` returns those bits with bits 7:4 always zero. Bit 0 enables receive data, bit 1 transmit empty, bit 2 line status and bit 3 modem status.
- R3: `iir` bit 0 is 1 when no enabled source is pending and 0 otherwise. `iir` bits 7:3 are always zero. `irq` equals the inverse of `iir` bit 0.
- R4: `iir` bits 2:1 give the highest-ranked enabled pending source. From highest to lowest: line status 11, receive data 10, transmit empty 01, modem status 00.
- R5: A rise on any bit of `lsr_err` (overrun, parity, framing, break) makes line status pending. An `lsr_rd` pulse clears it.
- R6: Receive data is pending exactly while `rx_avail` was high at the last clock edge. It needs no read strobe to clear.
- R7: A rise of `thr_empty` makes transmit empty pending. A `thr_wr` pulse clears it.
- R8: An `iir_rd` pulse clears transmit empty only when transmit empty is the reported source. Otherwise the pulse changes nothing.
- R9: An enable register write with bit 1 set while `thr_empty` is high makes transmit empty pending again at once.
- R10: A rise on any bit of `msr_delta` (CTS, DSR, ring, carrier change) makes modem status pending. An `msr_rd` pulse clears it.
- R11: A masked source keeps its pending flag. Enabling it later reports it without a new event.
- R12: If a new raise and a clear for the same source fall in the same cycle, the source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 4 | Enable register write data |
| iir_rd | input | 1 | Identification byte read strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| rx_avail | input | 1 | Receive data ready or trigger level reached |
| thr_empty | input | 1 | Transmit holding register empty level |
| lsr_err | input | 4 | Overrun, parity, framing and break flags |
| msr_delta | input | 4 | CTS, DSR, ring and carrier change flags |
| ier_rdata | output | 8 | Enable register read value |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that the error and change flags are levels held by the surrounding registers. They count a new event only where a flag bit goes from 0 to 1 between two samples. They also assume that no enable write arrives in the cycle they examine, because a write can mask the source being checked. The stimulus drives every strobe and level only at the falling edge. The directed phase never overlaps an enable write with an event under check. The random phase applies enable writes rarely, and the cycle-by-cycle reference model still covers those cycles.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NSRC = 4;

    // Source index equals its enable register bit
    localparam int IDX_RX = 0;
    localparam int IDX_TH = 1;
    localparam int IDX_LS = 2;
    localparam int IDX_MS = 3;

    typedef enum logic [1:0] {
        SRC_MS = 2'b00,
        SRC_TH = 2'b01,
        SRC_RX = 2'b10,
        SRC_LS = 2'b11
    } src_code_e;

    function automatic src_code_e code_of(input int idx);
        case (idx)
            IDX_RX:  return SRC_RX;
            IDX_TH:  return SRC_TH;
            IDX_LS:  return SRC_LS;
            default: return SRC_MS;
        endcase
    endfunction

    // Rank 0 is the highest priority
    function automatic int idx_at_rank(input int rank);
        case (rank)
            0:       return IDX_LS;
            1:       return IDX_RX;
            2:       return IDX_TH;
            default: return IDX_MS;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_edge.sv
module uart_irq_edge #(
    parameter int         W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic         rise_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
        rise_o = |(lvl_i & ~prev_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/uart_irq_flag.sv
module uart_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (clr_i) pend_d = 1'b0;
        if (set_i) pend_d = 1'b1;   // a fresh event outranks a clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NSRC-1:0] pend_i,
    input  logic [NSRC-1:0] ena_i,
    output logic            any_o,
    output src_code_e       code_o
);
    logic [NSRC-1:0] live;

    always_comb begin
        live   = pend_i & ena_i;
        any_o  = |live;
        code_o = SRC_MS;
        // walk from lowest to highest rank so the highest rank wins
        for (int r = NSRC - 1; r >= 0; r--) begin
            if (live[idx_at_rank(r)]) code_o = code_of(idx_at_rank(r));
        end
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int ERR_W = 4,
    parameter int DLT_W = 4,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_wr,
    input  logic [NSRC-1:0]  ier_wdata,
    input  logic             iir_rd,
    input  logic             lsr_rd,
    input  logic             msr_rd,
    input  logic             thr_wr,
    input  logic             rx_avail,
    input  logic             thr_empty,
    input  logic [ERR_W-1:0] lsr_err,
    input  logic [DLT_W-1:0] msr_delta,
    output logic [BUS_W-1:0] ier_rdata,
    output logic [BUS_W-1:0] iir,
    output logic             irq
);
    localparam int PAD_W = BUS_W - NSRC;
    localparam int ID_PAD_W = BUS_W - 3;

    typedef struct packed {
        logic [NSRC-1:0] ier;
        logic            rx;
    } st_t;

    st_t st_d, st_q;

    logic [NSRC-1:0] pend;
    logic            any;
    src_code_e       code;
    logic            ls_rise, ms_rise, th_rise;
    logic            th_set, th_clr;

    uart_irq_edge #(.W(ERR_W)) u_ls_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(lsr_err), .rise_o(ls_rise));

    uart_irq_edge #(.W(DLT_W)) u_ms_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(msr_delta), .rise_o(ms_rise));

    // reset previous level high: an already-empty holder is not an event
    uart_irq_edge #(.W(1), .RST_VAL(1'b1)) u_th_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(thr_empty), .rise_o(th_rise));

    always_comb begin
        th_set = th_rise | (ier_wr & ier_wdata[IDX_TH] & thr_empty);
        th_clr = thr_wr | (iir_rd & any & (code == SRC_TH));
    end

    uart_irq_flag u_ls_flag (
        .clk(clk), .rst_n(rst_n), .set_i(ls_rise), .clr_i(lsr_rd),
        .pend_o(pend[IDX_LS]));

    uart_irq_flag u_ms_flag (
        .clk(clk), .rst_n(rst_n), .set_i(ms_rise), .clr_i(msr_rd),
        .pend_o(pend[IDX_MS]));

    uart_irq_flag u_th_flag (
        .clk(clk), .rst_n(rst_n), .set_i(th_set), .clr_i(th_clr),
        .pend_o(pend[IDX_TH]));

    assign pend[IDX_RX] = st_q.rx;

    always_comb begin
        st_d    = st_q;
        st_d.rx = rx_avail;
        if (ier_wr) st_d.ier = ier_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    uart_irq_prio u_prio (
        .pend_i(pend), .ena_i(st_q.ier), .any_o(any), .code_o(code));

    always_comb begin
        ier_rdata = {{PAD_W{1'b0}}, st_q.ier};
        iir       = {{ID_PAD_W{1'b0}}, code, ~any};
        irq       = any;
    end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ier_wr,
    input logic       thr_wr,
    input logic       thr_empty,
    input logic [3:0] lsr_err,
    input logic [7:0] ier_rdata,
    input logic [7:0] iir,
    input logic       irq
);
    // R3: request line mirrors the no-pending bit
    p_irq_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !iir[0]);

    // R3: unused identification bits stay zero
    p_iir_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
        iir[7:3] == 5'd0);

    // R2: enable readback upper bits zero
    p_ier_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ier_rdata[7:4] == 4'd0);

    // R4: nothing enabled means nothing requested
    p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_rdata[3:0] == 4'd0) |-> !irq);

    // R5: a new line error with line status enabled is reported next
    p_ls_report_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_rdata[2] && !ier_wr && (|(lsr_err & ~$past(lsr_err))))
        |=> (iir[3:0] == 4'b0110));

    // R7: holding write with no new empty event leaves transmit empty unreported
    p_th_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !thr_empty && !ier_wr)
        |=> !(iir[3:0] == 4'b0010));
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .thr_wr(thr_wr),
    .thr_empty(thr_empty), .lsr_err(lsr_err), .ier_rdata(ier_rdata),
    .iir(iir), .irq(irq));

// File: tb/uart_irq_ident_tb_top.sv
`timescale 1ns/1ps
module uart_irq_ident_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ier_wr = 0, iir_rd = 0, lsr_rd = 0, msr_rd = 0, thr_wr = 0;
    logic [3:0] ier_wdata = 0;
    logic       rx_avail = 0, thr_empty = 1;
    logic [3:0] lsr_err = 0, msr_delta = 0;
    logic [7:0] ier_rdata, iir;
    logic       irq;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_irq_ident dut_i (
        .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .iir_rd(iir_rd), .lsr_rd(lsr_rd), .msr_rd(msr_rd), .thr_wr(thr_wr),
        .rx_avail(rx_avail), .thr_empty(thr_empty), .lsr_err(lsr_err),
        .msr_delta(msr_delta), .ier_rdata(ier_rdata), .iir(iir), .irq(irq));

    // behavioural reference
    logic [3:0] m_ier;
    bit m_rx, m_ls, m_ms, m_th, m_pt;
    logic [3:0] m_pe, m_pd;

    function automatic logic [7:0] m_iir();
        if (m_ls && m_ier[2]) return 8'h06;
        if (m_rx && m_ier[0]) return 8'h04;
        if (m_th && m_ier[1]) return 8'h02;
        if (m_ms && m_ier[3]) return 8'h00;
        return 8'h01;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ier <= 0; m_rx <= 0; m_ls <= 0; m_ms <= 0; m_th <= 0;
            m_pt <= 1; m_pe <= 0; m_pd <= 0;
        end else begin
            logic [7:0] cur;
            cur = m_iir();
            if ((lsr_err & ~m_pe) != 0) m_ls <= 1; else if (lsr_rd) m_ls <= 0;
            if ((msr_delta & ~m_pd) != 0) m_ms <= 1; else if (msr_rd) m_ms <= 0;
            if ((thr_empty && !m_pt) || (ier_wr && ier_wdata[1] && thr_empty)) m_th <= 1;
            else if (thr_wr || (iir_rd && cur == 8'h02)) m_th <= 0;
            m_rx <= rx_avail;
            if (ier_wr) m_ier <= ier_wdata;
            m_pe <= lsr_err; m_pd <= msr_delta; m_pt <= thr_empty;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // one clock; outputs checked against the model at the falling edge
    task automatic tick();
        @(negedge clk);
        chk("R4 model iir", iir, m_iir());
        chk("R3 model irq", {7'd0, irq}, {7'd0, m_iir() != 8'h01});
        chk("R2 model ier", ier_rdata, {4'd0, m_ier});
        ier_wr = 0; iir_rd = 0; lsr_rd = 0; msr_rd = 0; thr_wr = 0;
    endtask

    task automatic wr_ier(input logic [3:0] v);
        ier_wr = 1; ier_wdata = v; tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 iir", iir, 8'h01);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 ier", ier_rdata, 8'h00);

        wr_ier(4'hF);
        chk("R9 rearm", iir, 8'h02);
        chk("R3 irq", {7'd0, irq}, 8'h01);
        chk("R2 ier", ier_rdata, 8'h0F);
        wr_ier(4'h5);
        chk("R2 ier5", ier_rdata, 8'h05);
        chk("R11 th masked", iir, 8'h01);
        wr_ier(4'hD);
        chk("R11 th kept", iir, 8'h01);
        wr_ier(4'hF);
        rx_avail = 1; tick();
        chk("R6 rx over th", iir, 8'h04);
        lsr_err = 4'b0010; tick();
        chk("R5 ls top", iir, 8'h06);
        iir_rd = 1; tick();
        chk("R8 read ls kept", iir, 8'h06);
        lsr_rd = 1; tick();
        chk("R5 ls clr", iir, 8'h04);
        rx_avail = 0; tick();
        chk("R8 th survived", iir, 8'h02);
        iir_rd = 1; tick();
        chk("R8 th read clr", iir, 8'h01);
        chk("R3 idle irq", {7'd0, irq}, 8'h00);
        msr_delta = 4'b1000; tick();
        chk("R10 ms", iir, 8'h00);
        thr_empty = 0; tick();
        thr_empty = 1; tick();
        chk("R7 th rise", iir, 8'h02);
        thr_wr = 1; thr_empty = 0; tick();
        chk("R7 th wr clr", iir, 8'h00);
        msr_rd = 1; tick();
        chk("R10 ms clr", iir, 8'h01);
        wr_ier(4'h0);
        msr_delta = 4'b1001; lsr_err = 4'b0011; tick();
        chk("R11 all masked", iir, 8'h01);
        wr_ier(4'hC);
        chk("R11 ls late", iir, 8'h06);
        lsr_err = 4'b0111; lsr_rd = 1; tick();
        chk("R12 set wins", iir, 8'h06);
        lsr_rd = 1; tick();
        chk("R5 then ms", iir, 8'h00);
        msr_rd = 1; tick();
        chk("R10 idle", iir, 8'h01);

        // random phase against the reference
        for (int i = 0; i < 3000; i++) begin
            ier_wr    = ($urandom_range(0, 15) == 0);
            ier_wdata = 4'($urandom);
            iir_rd    = ($urandom_range(0, 3) == 0);
            lsr_rd    = ($urandom_range(0, 5) == 0);
            msr_rd    = ($urandom_range(0, 5) == 0);
            thr_wr    = ($urandom_range(0, 4) == 0);
            if ($urandom_range(0, 3) == 0) rx_avail = ~rx_avail;
            if ($urandom_range(0, 3) == 0) thr_empty = ~thr_empty;
            if ($urandom_range(0, 4) == 0) lsr_err = 4'($urandom);
            if ($urandom_range(0, 4) == 0) msr_delta = 4'($urandom);
            tick();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule